// File: doc/BRIEF.md
# Per-Port Transmit Cell Counter with Rollover Interrupt

This block keeps one 16-bit tally of transmitted cells for each of four ports. Every port has a single-cycle increment strobe from the upstream cell logic. Each strobe adds one to that port's tally. Software reaches the block through a small synchronous register port. That port offers the tallies, a per-port interrupt-enable register and a latched rollover status register.

The enable bit of a port sets what happens at the top of the range. With the bit clear, the tally sticks at 65,535. With the bit set, the tally wraps to zero, keeps counting, and latches a status bit for that port. Reading a tally returns its value and zeroes it. Reading the status register returns the latched bits and clears them. One interrupt line is high while any latched status bit has its enable set.

The register map is decoded on a 3-bit address:

| Address | Register |
|---|---|
| 0 to 3 | Tally of port 0 to 3 |
| 4 | Enable register, one bit per port |
| 5 | Status register, one bit per port |

A read is requested with `rd_en_i`. Its data appears on `rdata_o` after the next rising clock edge, and `rdata_o` then holds that value until the next read.

Top module: `cellcnt_top`

## Requirements
- R1: After reset, every tally, the enable register, the status register, `rdata_o` and `irq_o` are zero.
- R2: A high bit i of `inc_i` at a clock edge adds one to tally i only. The other tallies do not change.
- R3: While enable bit i is 0, a tally at 65,535 stays at 65,535 on further increments. Its status bit is not set.
- R4: While enable bit i is 1, an increment of a tally at 65,535 makes it 0 and sets status bit i. Later increments count on from 0.
- R5: A read of address i (0 to 3) puts the tally's value before that edge on `rdata_o` after the edge, and sets the tally to 0.
- R6: When an increment of port i falls in the same cycle as a read of address i, the read returns the old value and the tally becomes 1.
- R7: A read of address 5 returns the status bits in `rdata_o[3:0]`, with bit i for port i and upper bits 0. It then clears the status bits.
- R8: When a port rolls over in the same cycle as a status read, the read returns the old status and that port's status bit stays set afterwards.
- R9: `irq_o` is 1 exactly when some status bit i is set while enable bit i is also set. Clearing an enable bit masks that port's interrupt without clearing its status bit.
- R10: A write with `wr_en_i` to address 4 loads `wdata_i[3:0]` into the enable register, bit i for port i. A read of address 4 returns it in `rdata_o[3:0]`. Writes to any other address change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| inc_i | input | 4 | Per-port cell-sent strobe, bit i for port i |
| rd_en_i | input | 1 | Register read strobe |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 4 | Write data for the enable register |
| rdata_o | output | 16 | Registered read data |
| irq_o | output | 1 | Combined, masked rollover interrupt |

## Verification
A single clock edge can carry two events together: a clear caused by a read, and an increment or a rollover of the same state. The bench provokes the first case by raising a port's strobe in the same cycle as a read of that port's tally. It then expects the old value on the read and a tally of 1 on the next read. For the second case, the bench drives one port to 65,535 with its enable set. It then reads the status register in the cycle of the wrapping increment. The returned status must not contain the new bit, while `irq_o` must stay high and a second status read must show the bit.

// File: rtl/cellcnt_pkg.sv
package cellcnt_pkg;

    typedef enum logic [1:0] {
        REG_TALLY  = 2'd0,
        REG_ENABLE = 2'd1,
        REG_STATUS = 2'd2,
        REG_NONE   = 2'd3
    } reg_kind_e;

    // Tallies sit at 0..nport-1, then the enable and the status register.
    function automatic reg_kind_e decode_addr(input int unsigned a, input int unsigned nport);
        if (a < nport) begin
            return REG_TALLY;
        end else if (a == nport) begin
            return REG_ENABLE;
        end else if (a == nport + 1) begin
            return REG_STATUS;
        end
        return REG_NONE;
    endfunction

endpackage

// File: rtl/cellcnt_tally.sv
module cellcnt_tally #(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             inc_i,
    input  logic             clr_i,
    input  logic             wrap_en_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             roll_o
);
    localparam logic [CNT_W-1:0] TOP = '1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;
    logic             at_top;

    assign at_top = (cnt_q == TOP);

    always_comb begin
        cnt_d  = cnt_q;
        roll_o = 1'b0;
        if (clr_i) begin
            // A strobe landing with the clearing read still counts.
            cnt_d = inc_i ? CNT_W'(1) : '0;
        end else if (inc_i) begin
            if (!at_top) begin
                cnt_d = cnt_q + CNT_W'(1);
            end else if (wrap_en_i) begin
                cnt_d  = '0;
                roll_o = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt_o = cnt_q;

    p_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (inc_i && !clr_i && !at_top) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

    p_idle_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!inc_i && !clr_i) |=> $stable(cnt_q));

    p_saturate_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (inc_i && !clr_i && at_top && !wrap_en_i) |=> (cnt_q == TOP));

    p_wrap_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (inc_i && !clr_i && at_top && wrap_en_i) |=> (cnt_q == '0));

    p_read_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_i && !inc_i) |=> (cnt_q == '0));

    p_clear_keeps_inc_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_i && inc_i) |=> (cnt_q == CNT_W'(1)));

endmodule

// File: rtl/cellcnt_status.sv
module cellcnt_status #(
    parameter int NPORT = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [NPORT-1:0] roll_i,
    input  logic             clr_i,
    input  logic [NPORT-1:0] en_i,
    output logic [NPORT-1:0] st_o,
    output logic             irq_o
);
    logic [NPORT-1:0] st_q;

    for (genvar g = 0; g < NPORT; g++) begin : g_bit
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                st_q[g] <= 1'b0;
            end else if (roll_i[g]) begin
                // A new rollover outranks a clearing read in the same cycle.
                st_q[g] <= 1'b1;
            end else if (clr_i) begin
                st_q[g] <= 1'b0;
            end
        end

        p_roll_sets_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
            roll_i[g] |=> st_q[g]);

        p_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (st_q[g] && !clr_i) |=> st_q[g]);
    end

    assign st_o  = st_q;
    assign irq_o = |(st_q & en_i);

    p_read_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_i && (roll_i == '0)) |=> (st_q == '0));

    p_irq_masked_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> ((en_i != '0) && (st_q != '0)));

endmodule

// File: rtl/cellcnt_regif.sv
module cellcnt_regif
    import cellcnt_pkg::*;
#(
    parameter int NPORT  = 4,
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 3
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              rd_en_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [NPORT-1:0]  wdata_i,
    input  logic [CNT_W-1:0]  cnt_i [NPORT],
    input  logic [NPORT-1:0]  st_i,
    output logic [NPORT-1:0]  en_o,
    output logic [NPORT-1:0]  clr_cnt_o,
    output logic              clr_st_o,
    output logic [CNT_W-1:0]  rdata_o
);
    localparam int PAD_W = CNT_W - NPORT;

    reg_kind_e        kind;
    logic [NPORT-1:0] en_q;
    logic [CNT_W-1:0] rd_mux;
    logic [CNT_W-1:0] rdata_q;
    logic             en_wr;

    assign kind  = decode_addr(32'(addr_i), NPORT);
    assign en_wr = wr_en_i && (kind == REG_ENABLE);

    always_comb begin
        rd_mux    = '0;
        clr_cnt_o = '0;
        clr_st_o  = 1'b0;
        unique case (kind)
            REG_TALLY: begin
                for (int i = 0; i < NPORT; i++) begin
                    if (32'(addr_i) == i) begin
                        rd_mux       = cnt_i[i];
                        clr_cnt_o[i] = rd_en_i;
                    end
                end
            end
            REG_ENABLE: rd_mux = {{PAD_W{1'b0}}, en_q};
            REG_STATUS: begin
                rd_mux   = {{PAD_W{1'b0}}, st_i};
                clr_st_o = rd_en_i;
            end
            REG_NONE:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            en_q    <= '0;
            rdata_q <= '0;
        end else begin
            if (en_wr) begin
                en_q <= wdata_i;
            end
            if (rd_en_i) begin
                rdata_q <= rd_mux;
            end
        end
    end

    assign en_o    = en_q;
    assign rdata_o = rdata_q;

    p_en_load_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && kind == REG_ENABLE) |=> (en_q == $past(wdata_i)));

    p_en_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(wr_en_i && kind == REG_ENABLE) |=> $stable(en_q));

    p_one_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({clr_cnt_o, clr_st_o}));

    p_rdata_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_en_i |=> $stable(rdata_q));

endmodule

// File: rtl/cellcnt_top.sv
module cellcnt_top #(
    parameter int NPORT  = 4,
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 3
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [NPORT-1:0]  inc_i,
    input  logic              rd_en_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [NPORT-1:0]  wdata_i,
    output logic [CNT_W-1:0]  rdata_o,
    output logic              irq_o
);
    logic [CNT_W-1:0] cnt   [NPORT];
    logic [NPORT-1:0] roll;
    logic [NPORT-1:0] en;
    logic [NPORT-1:0] st;
    logic [NPORT-1:0] clr_cnt;
    logic             clr_st;

    for (genvar g = 0; g < NPORT; g++) begin : g_port
        cellcnt_tally #(.CNT_W(CNT_W)) u_tally (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .inc_i     (inc_i[g]),
            .clr_i     (clr_cnt[g]),
            .wrap_en_i (en[g]),
            .cnt_o     (cnt[g]),
            .roll_o    (roll[g])
        );

        p_roll_needs_en_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (inc_i[g] && !en[g]) |=> !st[g] || $past(st[g]));
    end

    cellcnt_status #(.NPORT(NPORT)) u_status (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .roll_i (roll),
        .clr_i  (clr_st),
        .en_i   (en),
        .st_o   (st),
        .irq_o  (irq_o)
    );

    cellcnt_regif #(.NPORT(NPORT), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regif (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .rd_en_i   (rd_en_i),
        .wr_en_i   (wr_en_i),
        .addr_i    (addr_i),
        .wdata_i   (wdata_i),
        .cnt_i     (cnt),
        .st_i      (st),
        .en_o      (en),
        .clr_cnt_o (clr_cnt),
        .clr_st_o  (clr_st),
        .rdata_o   (rdata_o)
    );

    initial begin
        p_map_fits_r10: assert (NPORT + 2 <= (1 << ADDR_W) && NPORT <= CNT_W);
    end

endmodule

// File: tb/test_cellcnt_top.sv
module test_cellcnt_top;
    localparam int NP = 4;
    localparam int CW = 16;
    localparam int AW = 3;
    localparam logic [AW-1:0] A_EN = 3'd4;
    localparam logic [AW-1:0] A_ST = 3'd5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] inc = '0;
    logic          rd_en = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [NP-1:0] wdata = '0;
    logic [CW-1:0] rdata;
    logic          irq;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    cellcnt_top #(.NPORT(NP), .CNT_W(CW), .ADDR_W(AW)) i_cellcnt_top (
        .clk_i   (clk),
        .rst_ni  (rst_n),
        .inc_i   (inc),
        .rd_en_i (rd_en),
        .wr_en_i (wr_en),
        .addr_i  (addr),
        .wdata_i (wdata),
        .rdata_o (rdata),
        .irq_o   (irq)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [NP-1:0] with_inc, output int val);
        @(negedge clk);
        rd_en = 1'b1; addr = a; inc = with_inc;
        @(negedge clk);
        rd_en = 1'b0; inc = '0;
        val = int'(rdata);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [NP-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse(input logic [NP-1:0] pat, input int n);
        @(negedge clk);
        inc = pat;
        repeat (n) @(negedge clk);
        inc = '0;
    endtask

    task automatic t_reset;
        int v;
        check("R1 rdata", int'(rdata), 0);
        check("R1 irq", int'(irq), 0);
        for (int i = 0; i < NP; i++) begin
            rd(AW'(i), '0, v);
            check($sformatf("R1 tally%0d", i), v, 0);
        end
        rd(A_EN, '0, v); check("R1 enable", v, 0);
        rd(A_ST, '0, v); check("R1 status", v, 0);
    endtask

    task automatic t_basic_count;
        int v;
        pulse(4'b0011, 3);
        pulse(4'b1000, 5);
        pulse(4'b0100, 1);
        rd(3'd0, '0, v); check("R2 tally0", v, 3);
        rd(3'd1, '0, v); check("R2 tally1", v, 3);
        rd(3'd2, '0, v); check("R2 tally2", v, 1);
        rd(3'd3, '0, v); check("R2 tally3", v, 5);
        rd(3'd3, '0, v); check("R5 tally3 cleared", v, 0);
        rd(3'd0, '0, v); check("R5 tally0 cleared", v, 0);
    endtask

    task automatic t_enable_reg;
        int v;
        wr(A_EN, 4'b1010);
        rd(A_EN, '0, v); check("R10 enable readback", v, 10);
        pulse(4'b0010, 2);
        wr(3'd1, 4'hF);
        wr(A_ST, 4'hF);
        wr(3'd7, 4'hF);
        rd(3'd1, '0, v); check("R10 write to tally ignored", v, 2);
        rd(A_ST, '0, v); check("R10 write to status ignored", v, 0);
        rd(A_EN, '0, v); check("R10 enable unchanged", v, 10);
        wr(A_EN, 4'b0000);
    endtask

    task automatic t_clear_with_inc;
        int v;
        pulse(4'b0010, 3);
        rd(3'd1, 4'b0010, v); check("R6 read old value", v, 3);
        rd(3'd1, '0, v); check("R6 tally is one", v, 1);
    endtask

    task automatic t_overflow_modes;
        int v;
        wr(A_EN, 4'b0101);
        pulse(4'hF, 65535);
        check("R9 no irq before wrap", int'(irq), 0);
        pulse(4'hF, 1);
        check("R4 irq after wrap", int'(irq), 1);
        rd(A_ST, '0, v); check("R7 status bits", v, 5);
        check("R7 irq cleared by read", int'(irq), 0);
        rd(A_ST, '0, v); check("R7 status cleared", v, 0);
        rd(3'd1, '0, v); check("R3 tally1 saturated", v, 65535);
        rd(3'd3, '0, v); check("R3 tally3 saturated", v, 65535);
        rd(3'd0, '0, v); check("R4 tally0 wrapped", v, 0);
        pulse(4'b0100, 1);
        rd(3'd2, '0, v); check("R4 tally2 keeps counting", v, 1);
    endtask

    task automatic t_roll_with_status_read;
        int v;
        pulse(4'b0100, 65535);
        rd(A_ST, 4'b0100, v); check("R8 read returns old status", v, 0);
        check("R8 irq held", int'(irq), 1);
        wr(A_EN, 4'b0000);
        check("R9 irq masked", int'(irq), 0);
        wr(A_EN, 4'b0100);
        check("R9 irq unmasked", int'(irq), 1);
        rd(A_ST, '0, v); check("R8 status bit kept", v, 4);
        check("R9 irq after clear", int'(irq), 0);
        rd(3'd2, '0, v); check("R4 tally2 wrapped to zero", v, 0);
    endtask

    task automatic finish_run;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic_count();
        t_enable_reg();
        t_clear_with_inc();
        t_overflow_modes();
        t_roll_with_status_read();
        finish_run();
    end

endmodule